// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block lets a clocked design read and write a 32K x 8 asynchronous static RAM. On the user side a request carries a 15-bit address, a read/write select and an 8-bit write word. It is taken on the clock edge where both request and ready are high. Completed reads return an 8-bit word together with a one-cycle valid pulse. On the memory side the controller drives the address bus and three active-low strobes: select, write and output enable. It shares the bidirectional data bus with the memory through a tri-state driver.

The length of every memory phase is a whole number of clock cycles. Each count comes from a nanosecond timing parameter and the clock-period parameter, by ceiling division with a floor of one cycle. A read holds select and output enable low until both the access time and the output-enable delay have passed, then registers the bus. A write first selects the chip with write and output enable high, so the bus can turn around. It then pulls write enable low with the controller's data on the bus, for at least the pulse width, the data setup time and the address setup time. Write enable and select rise on the same edge, which ends the write. Between accesses all strobes are high, the memory sits in standby and the data bus is released.

Top module: `sram_port_ctrl`

## Requirements
- R1: After reset and between accesses, memCeN, memWeN and memOeN are all 1 and reqReady is 1.
- R2: reqReady is 1 only in idle. A request is accepted on a rising edge where reqValid and reqReady are both 1, and reqReady is 0 in the following cycle.
- R3: A read holds memCeN and memOeN at 0 and memWeN at 1 for exactly max(ceil(tRC), ceil(tAA), ceil(tDOE)) cycles, where ceil(t) = max(1, ceil(t / CLK_NS)); 2 cycles with the defaults. The bus is sampled on the last edge of that window.
- R4: rspValid is 1 for one cycle after each completed read, with rspData holding the word read. rspData then keeps that value until the next read completes, and writes do not change it.
- R5: A write holds memWeN at 0 with memCeN at 0 and memOeN at 1 for exactly max(ceil(tWC), ceil(tPWE), ceil(tAW), ceil(tSD)) cycles; 2 with the defaults.
- R6: Before memWeN falls, a write holds memCeN at 0 with memWeN and memOeN at 1 for exactly ceil(tHZOE) cycles; 1 with the defaults.
- R7: The controller drives memData only while memWeN is 0, and it drives the accepted write word. memOeN and memWeN are never 0 together.
- R8: memAddr equals the accepted request address for every cycle in which memCeN is 0.
- R9: A word written to an address is returned by any later read of that address, including a read issued right after the write and reads of addresses 0 and 32767.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Controller idle, a request can be taken |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 15 | Word address |
| reqWdata | input | 8 | Write word |
| rspValid | output | 1 | One-cycle pulse when read data is updated |
| rspData | output | 8 | Last word read |
| memAddr | output | 15 | Memory address bus |
| memCeN | output | 1 | Memory select, active low |
| memWeN | output | 1 | Memory write enable, active low |
| memOeN | output | 1 | Memory output enable, active low |
| memData | inout | 8 | Shared memory data bus |

## Verification
Every cycle, the assertions check that output and write enable are never low together, that the driver is on only while output enable is high, and that the address holds still while the chip is selected. They also check the exact length of each write-enable pulse, the select-only cycle that comes before it, the sampling of read data while output enable is low, and that rspData holds between reads. Whether the data actually lands in the memory and comes back on a later read can only be shown by the bench's scenarios. The same goes for the handshake under back-to-back requests and the boundary addresses. The bench runs these against a behavioural memory model with a scoreboard of expected read words.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_READ   = 2'd1,
    ST_WSETUP = 2'd2,
    ST_WPULSE = 2'd3
  } ctlState_t;

  typedef struct packed {
    logic latchReq;
    logic capture;
    logic drvOn;
  } dpStrobe_t;

  function automatic int nsToCycles(input int ns, input int periodNs);
    int c;
    c = (ns + periodNs - 1) / periodNs;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctrl_seq.sv
module sram_ctrl_seq
  import sram_ctrl_pkg::*;
#(
  parameter int RD_CYC   = 2,
  parameter int TURN_CYC = 1,
  parameter int WR_CYC   = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      reqWrite,
  output logic      reqReady,
  output logic      rspValid,
  output logic      memCeN,
  output logic      memWeN,
  output logic      memOeN,
  output dpStrobe_t strobe
);

  localparam int MAX_CYC = maxOf(maxOf(RD_CYC, TURN_CYC), WR_CYC);
  localparam int CW      = $clog2(MAX_CYC + 1);

  ctlState_t       state, stateNext;
  logic [CW-1:0]   phaseCnt, phaseCntNext;
  logic            lastCycle;

  assign lastCycle = (phaseCnt == '0);

  always_comb begin
    stateNext    = state;
    phaseCntNext = phaseCnt;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          if (reqWrite) begin
            stateNext    = ST_WSETUP;
            phaseCntNext = CW'(TURN_CYC - 1);
          end else begin
            stateNext    = ST_READ;
            phaseCntNext = CW'(RD_CYC - 1);
          end
        end
      end
      ST_READ: begin
        if (lastCycle) stateNext = ST_IDLE;
        else phaseCntNext = phaseCnt - 1'b1;
      end
      ST_WSETUP: begin
        if (lastCycle) begin
          stateNext    = ST_WPULSE;
          phaseCntNext = CW'(WR_CYC - 1);
        end else begin
          phaseCntNext = phaseCnt - 1'b1;
        end
      end
      ST_WPULSE: begin
        if (lastCycle) stateNext = ST_IDLE;
        else phaseCntNext = phaseCnt - 1'b1;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phaseCnt <= '0;
      rspValid <= 1'b0;
    end else begin
      state    <= stateNext;
      phaseCnt <= phaseCntNext;
      rspValid <= strobe.capture;
    end
  end

  assign reqReady        = (state == ST_IDLE);
  assign memCeN          = (state == ST_IDLE);
  assign memWeN          = (state != ST_WPULSE);
  assign memOeN          = (state != ST_READ);
  assign strobe.latchReq = (state == ST_IDLE) && reqValid;
  assign strobe.capture  = (state == ST_READ) && lastCycle;
  assign strobe.drvOn    = (state == ST_WPULSE);

  // Checker counters observed at the memory pins
  logic [CW:0] weLowRun;
  logic [CW:0] ceOnlyRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      weLowRun  <= '0;
      ceOnlyRun <= '0;
    end else begin
      weLowRun  <= !memWeN ? weLowRun + 1'b1 : '0;
      ceOnlyRun <= (!memCeN && memWeN && memOeN) ? ceOnlyRun + 1'b1 : '0;
    end
  end

  // R1
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (memCeN && memWeN && memOeN));

  // R2
  accept_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqReady && reqValid) |=> !reqReady);

  // R5
  we_pulse_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> (weLowRun == (CW+1)'(WR_CYC)));

  // R6
  we_setup_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memWeN) |-> (ceOnlyRun == (CW+1)'(TURN_CYC)));

  // R3
  rd_sample_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(!memOeN && !memCeN && memWeN));

  // R7
  no_oe_we_overlap_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(!memOeN && !memWeN));

endmodule

// File: rtl/sram_ctrl_dp.sv
module sram_ctrl_dp
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic [ADDR_W-1:0] memAddr,
  inout  wire  [DATA_W-1:0] memData,
  output logic [DATA_W-1:0] rspData
);

  logic [DATA_W-1:0] wdataQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memAddr <= '0;
      wdataQ  <= '0;
      rspData <= '0;
    end else begin
      if (strobe.latchReq) begin
        memAddr <= reqAddr;
        wdataQ  <= reqWdata;
      end
      if (strobe.capture) rspData <= memData;
    end
  end

  assign memData = strobe.drvOn ? wdataQ : 'z;

endmodule

// File: rtl/sram_port_ctrl.sv
module sram_port_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W    = 15,
  parameter int DATA_W    = 8,
  parameter int CLK_NS    = 10,
  parameter int T_RC_NS   = 15,
  parameter int T_AA_NS   = 15,
  parameter int T_DOE_NS  = 7,
  parameter int T_HZOE_NS = 8,
  parameter int T_WC_NS   = 15,
  parameter int T_PWE_NS  = 10,
  parameter int T_AW_NS   = 10,
  parameter int T_SD_NS   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memWeN,
  output logic              memOeN,
  inout  wire  [DATA_W-1:0] memData
);

  localparam int RD_CYC = maxOf(nsToCycles(T_RC_NS, CLK_NS),
                          maxOf(nsToCycles(T_AA_NS, CLK_NS), nsToCycles(T_DOE_NS, CLK_NS)));
  localparam int TURN_CYC = nsToCycles(T_HZOE_NS, CLK_NS);
  localparam int WR_CYC = maxOf(maxOf(nsToCycles(T_WC_NS, CLK_NS), nsToCycles(T_PWE_NS, CLK_NS)),
                          maxOf(nsToCycles(T_AW_NS, CLK_NS), nsToCycles(T_SD_NS, CLK_NS)));

  dpStrobe_t strobe;

  sram_ctrl_seq #(
    .RD_CYC  (RD_CYC),
    .TURN_CYC(TURN_CYC),
    .WR_CYC  (WR_CYC)
  ) u_seq (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqReady(reqReady),
    .rspValid(rspValid),
    .memCeN  (memCeN),
    .memWeN  (memWeN),
    .memOeN  (memOeN),
    .strobe  (strobe)
  );

  sram_ctrl_dp #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .reqAddr (reqAddr),
    .reqWdata(reqWdata),
    .memAddr (memAddr),
    .memData (memData),
    .rspData (rspData)
  );

  // R7
  drv_only_oe_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.drvOn |-> (memOeN && !memWeN));

  // R8
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!memCeN && $past(!memCeN)) |-> $stable(memAddr));

  // R4
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> $stable(rspData));

endmodule

// File: tb/sram_port_ctrl_bench.sv
module sram_port_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int RD_CYC   = 2;
  localparam int TURN_CYC = 1;
  localparam int WR_CYC   = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [14:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic        reqReady, rspValid;
  logic [7:0]  rspData;
  logic [14:0] memAddr;
  logic        memCeN, memWeN, memOeN;
  wire  [7:0]  memData;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_port_ctrl u_sram_port_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspData(rspData), .memAddr(memAddr),
    .memCeN(memCeN), .memWeN(memWeN), .memOeN(memOeN), .memData(memData)
  );

  // Behavioural memory model
  logic [7:0] store [int];
  logic [7:0] modelOut;
  logic       modelDrive;
  always @(memWeN or memCeN or memData or memAddr)
    if (!memWeN && !memCeN) store[int'(memAddr)] = memData;
  always @* begin
    modelDrive = !memCeN && !memOeN && memWeN;
    modelOut   = store.exists(int'(memAddr)) ? store[int'(memAddr)] : 8'h00;
  end
  assign memData = modelDrive ? modelOut : 8'bz;

  // Reference and scoreboard
  logic [7:0] refMem [int];
  logic [7:0] expQ [$];
  logic [14:0] curAddr;
  logic [7:0]  curData;
  logic [7:0]  lastRead = 8'h00;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input bit wr, input logic [14:0] a, input logic [7:0] d);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d;
    curAddr = a; curData = d;
    @(negedge clk);
    reqValid = 1'b0;
    check(reqReady == 1'b0, "R2 ready after accept", int'(reqReady), 0);
  endtask

  task automatic doWrite(input logic [14:0] a, input logic [7:0] d);
    issue(1'b1, a, d);
    refMem[int'(a)] = d;
  endtask

  task automatic doRead(input logic [14:0] a);
    expQ.push_back(refMem.exists(int'(a)) ? refMem[int'(a)] : 8'h00);
    issue(1'b0, a, 8'h00);
  endtask

  // Monitor: scoreboard and phase timing
  int oeLow = 0, weLow = 0, ceOnly = 0;
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (rspValid) begin
        if (expQ.size() == 0) check(1'b0, "R4 unexpected rspValid", 1, 0);
        else begin
          logic [7:0] e;
          e = expQ.pop_front();
          check(rspData == e, "R9 read data", int'(rspData), int'(e));
          lastRead = e;
        end
      end else begin
        check(rspData == lastRead, "R4 rspData hold", int'(rspData), int'(lastRead));
      end
      if (!memCeN) check(memAddr == curAddr, "R8 address", int'(memAddr), int'(curAddr));
      if (!memOeN && !memWeN) check(1'b0, "R7 oe/we overlap", 1, 0);
      if (!memOeN) begin
        oeLow++;
        check(!memCeN && memWeN, "R3 read strobes", int'({memCeN, memWeN}), 1);
      end else if (oeLow > 0) begin
        check(oeLow == RD_CYC, "R3 read window", oeLow, RD_CYC);
        oeLow = 0;
      end
      if (!memCeN && memWeN && memOeN) ceOnly++;
      else if (!memWeN && ceOnly > 0) begin
        check(ceOnly == TURN_CYC, "R6 setup length", ceOnly, TURN_CYC);
        ceOnly = 0;
      end else if (memCeN) ceOnly = 0;
      if (!memWeN) begin
        weLow++;
        check(!memCeN && memOeN, "R5 write strobes", int'({memCeN, memOeN}), 1);
        check(memData == curData, "R7 driven word", int'(memData), int'(curData));
      end else if (weLow > 0) begin
        check(weLow == WR_CYC, "R5 pulse length", weLow, WR_CYC);
        weLow = 0;
      end
      if (reqReady)
        check(memCeN && memWeN && memOeN, "R1 idle strobes",
              int'({memCeN, memWeN, memOeN}), 7);
    end
  end

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(reqReady && memCeN && memWeN && memOeN, "R1 reset state",
          int'({reqReady, memCeN, memWeN, memOeN}), 15);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady == 1'b1, "R1 ready after reset", int'(reqReady), 1);
    doRead(15'd5);                       // R9 unwritten reads as 0
    doWrite(15'd0, 8'hA5);
    doWrite(15'h7FFF, 8'h3C);
    doRead(15'd0);
    doRead(15'h7FFF);
    doWrite(15'h1234, 8'hFF);
    doRead(15'h1234);                    // read right after write
    for (int i = 0; i < 16; i++) doWrite(15'(i * 997), 8'(i * 37 + 1));
    for (int i = 15; i >= 0; i--) doRead(15'(i * 997));
    doWrite(15'h0100, 8'h00);
    doWrite(15'h0100, 8'h81);            // overwrite
    doRead(15'h0100);
    repeat (4) @(negedge clk);           // R4 hold while idle
    doWrite(15'h0200, 8'h55);            // R4 write leaves rspData alone
    repeat (4) @(negedge clk);
    check(rspData == 8'h81, "R4 hold after write", int'(rspData), 8'h81);
    check(expQ.size() == 0, "R9 all reads returned", expQ.size(), 0);
    finishRun();
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    finishRun();
  end

endmodule